// File: doc/BRIEF.md
# PWM Timebase with Coherent Readback

This block produces the period timebase for a pair of pulse-width outputs. A 12-bit counter counts upward, one step per prescaler tick, from 1 to a programmable modulus and then wraps back to 1. Each output is high while the counter is at or below its own 12-bit duty value. Modulus and duty values are written as byte pairs into shadow registers. They reach the active compare logic only at a period wrap, so a period never sees a half-updated setting.

Software reads the counter over an 8-bit synchronous register port. Reading the high byte captures the low byte, so a high-then-low read sequence yields one coherent 12-bit value even while the counter runs. An enable bit gates the prescaler and the counter. A stop input freezes all state and forces both outputs low until it is released.

A small state machine governs activity. ST_OFF is the state with the enable bit clear. ST_RUN is the counting state. ST_HALT is the state while stop is asserted. The transitions are:
- arm: ST_OFF to ST_RUN.
- disarm: ST_RUN to ST_OFF.
- shelve: ST_OFF to ST_HALT.
- freeze: ST_RUN to ST_HALT.
- resume: ST_HALT to ST_RUN, taken when enabled.
- park: ST_HALT to ST_OFF, taken when disabled.

Stop takes priority over enable.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the control, modulus and duty registers read 0, the counter reads 0, and both outputs are low.
- R2: The counter runs 1, 2, …, M and then returns to 1, so one period lasts M ticks. Address 1 returns counter bits 11..8 in data bits 3..0 with bits 7..4 zero. Address 2 returns counter bits 7..0.
- R3: Control bits 2..1 (address 0) select a tick every 1, 2, 4 or 8 clocks for the values 0, 1, 2 and 3. The output period is therefore M·2^sel clocks.
- R4: A read of address 1 captures counter bits 7..0. The next read of address 2 returns that captured byte, however many cycles later it comes. A read of address 2 with no capture pending returns the live low byte.
- R5: Channel k is high while 1 ≤ counter ≤ duty k, which gives a high time of duty·2^sel clocks per period. A duty of 0 keeps it low.
- R6: Modulus and duty values written mid-period take effect only from the next wrap.
- R7: With control bit 0 (enable) clear, the prescaler is cleared, the counter holds its value and the outputs do not change.
- R8: While stop_req is high, both outputs are 0 in the same cycle, and the counter and all registers hold.
- R9: After stop_req falls, counting continues from the preserved counter value.
- R10: A modulus of 0 holds the counter at 0 and both outputs low.
- R11: The register map is as follows:
  - Address 0: control.
  - Addresses 3 and 4: modulus high byte (bits 3..0) and low byte.
  - Addresses 5 and 6: duty 0 high and low bytes.
  - Addresses 7 and 8: duty 1 high and low bytes.
  
  Unused high bits read 0. Writes to addresses 1 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| stop_req | input | 1 | Stop request: freeze state, force outputs low |
| pwm_out | output | 2 | PWM outputs, one per channel |

## Verification
A corrupted counter or active modulus appears first at the outputs. The spacing between rising edges and the high width change within the same period, and the bench measures both per vector. A latch that fails to hold shows up as a low byte that drifts between the high-byte read and a delayed low-byte read. A wrong state in the state machine appears within one tick as a counter that moves while stopped or disabled, or as outputs that are not forced low while stop is asserted.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
    localparam int ADDR_W  = 4;
    localparam int PSEL_W  = 2;

    localparam logic [ADDR_W-1:0] RA_CTRL      = 4'd0;
    localparam logic [ADDR_W-1:0] RA_CNT_HI    = 4'd1;
    localparam logic [ADDR_W-1:0] RA_CNT_LO    = 4'd2;
    localparam logic [ADDR_W-1:0] RA_MOD_HI    = 4'd3;
    localparam logic [ADDR_W-1:0] RA_MOD_LO    = 4'd4;
    localparam int                RA_DUTY_BASE = 5;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } run_state_e;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic              en;
    } ctrl_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwmtb_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int NCH    = 2,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [CNT_W-1:0]           cnt_i,
    output logic [DATA_W-1:0]          rdata,
    output ctrl_t                      ctrl_o,
    output logic [CNT_W-1:0]           mod_o,
    output logic [NCH-1:0][CNT_W-1:0]  duty_o
);
    localparam int HI_W = CNT_W - DATA_W;

    ctrl_t                      ctrl_q;
    logic [CNT_W-1:0]           mod_q;
    logic [NCH-1:0][CNT_W-1:0]  duty_q;
    logic [DATA_W-1:0]          lat_q;
    logic                       lat_vld_q;
    logic [DATA_W-1:0]          rdata_q;
    logic [DATA_W-1:0]          rd_mux;

    function automatic logic [ADDR_W-1:0] duty_addr(input int ch, input int lo);
        return ADDR_W'(RA_DUTY_BASE + 2 * ch + lo);
    endfunction

    // configuration writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mod_q  <= '0;
            duty_q <= '0;
        end else if (wr_en) begin
            if (addr == RA_CTRL)   ctrl_q <= ctrl_t'(wdata[PSEL_W:0]);
            if (addr == RA_MOD_HI) mod_q[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
            if (addr == RA_MOD_LO) mod_q[DATA_W-1:0] <= wdata;
            for (int c = 0; c < NCH; c++) begin
                if (addr == duty_addr(c, 0)) duty_q[c][CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
                if (addr == duty_addr(c, 1)) duty_q[c][DATA_W-1:0] <= wdata;
            end
        end
    end

    // low-byte capture on a high-byte read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q     <= '0;
            lat_vld_q <= 1'b0;
        end else if (rd_en && addr == RA_CNT_HI) begin
            lat_q     <= cnt_i[DATA_W-1:0];
            lat_vld_q <= 1'b1;
        end else if (rd_en && addr == RA_CNT_LO) begin
            lat_vld_q <= 1'b0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr == RA_CTRL)   rd_mux = DATA_W'(ctrl_q);
        if (addr == RA_CNT_HI) rd_mux = DATA_W'(cnt_i[CNT_W-1:DATA_W]);
        if (addr == RA_CNT_LO) rd_mux = lat_vld_q ? lat_q : cnt_i[DATA_W-1:0];
        if (addr == RA_MOD_HI) rd_mux = DATA_W'(mod_q[CNT_W-1:DATA_W]);
        if (addr == RA_MOD_LO) rd_mux = mod_q[DATA_W-1:0];
        for (int c = 0; c < NCH; c++) begin
            if (addr == duty_addr(c, 0)) rd_mux = DATA_W'(duty_q[c][CNT_W-1:DATA_W]);
            if (addr == duty_addr(c, 1)) rd_mux = duty_q[c][DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata  = rdata_q;
    assign ctrl_o = ctrl_q;
    assign mod_o  = mod_q;
    assign duty_o = duty_q;

    // R4: a pending capture is kept until the next high-byte read
    p_latch_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_vld_q && !(rd_en && addr == RA_CNT_HI)) |=> $stable(lat_q));

    // R2: padding bits of the counter high byte read zero
    p_hi_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == RA_CNT_HI) |=> (rdata_q[DATA_W-1:HI_W] == '0));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwmtb_pkg::*;
#(
    parameter int SEL_W = PSEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             run_i,
    input  logic [SEL_W-1:0] psel_i,
    output logic             tick_o
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    always_comb lim = ~({PRE_W{1'b1}} << psel_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (!en_i)  pre_q <= '0;
        else if (run_i)  pre_q <= (pre_q >= lim) ? '0 : pre_q + 1'b1;
    end

    assign tick_o = run_i && (pre_q >= lim);

    // R7: disabling clears the divider
    p_pre_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (pre_q == '0));

    // R3: divider stays within its selected range while the selection holds
    p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q <= lim) |=> ((pre_q <= lim) || !$stable(psel_i)));
endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwmtb_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int NCH   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_i,
    input  logic                       stop_i,
    input  logic                       tick_i,
    input  logic [CNT_W-1:0]           mod_i,
    input  logic [NCH-1:0][CNT_W-1:0]  duty_i,
    output logic                       run_o,
    output logic [CNT_W-1:0]           cnt_o,
    output logic [NCH-1:0][CNT_W-1:0]  duty_act_o
);
    run_state_e                 st_q;
    run_state_e                 st_d;
    logic [CNT_W-1:0]           cnt_q;
    logic [CNT_W-1:0]           mod_act_q;
    logic [NCH-1:0][CNT_W-1:0]  duty_act_q;
    logic                       wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state: stop outranks enable
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (stop_i)    st_d = ST_HALT;   // shelve
                else if (en_i) st_d = ST_RUN;    // arm
            end
            ST_RUN: begin
                if (stop_i)    st_d = ST_HALT;   // freeze
                else if (!en_i) st_d = ST_OFF;   // disarm
            end
            ST_HALT: begin
                if (!stop_i)   st_d = en_i ? ST_RUN : ST_OFF;  // resume / park
            end
            default:           st_d = ST_OFF;
        endcase
    end

    // state outputs
    always_comb begin
        run_o = (st_q == ST_RUN) && en_i && !stop_i;
    end

    assign wrap = (cnt_q >= mod_act_q);

    // period counter with shadow transfer at the wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            mod_act_q  <= '0;
            duty_act_q <= '0;
        end else if (tick_i) begin
            if (wrap) begin
                mod_act_q  <= mod_i;
                duty_act_q <= duty_i;
                cnt_q      <= (mod_i == '0) ? '0 : CNT_W'(1);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o      = cnt_q;
    assign duty_act_o = duty_act_q;

    // R2: counter never passes the active modulus
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= mod_act_q);

    // R10: zero modulus pins the counter at zero
    p_zero_mod_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_act_q == '0) |-> (cnt_q == '0));

    // R7: disabled counter holds
    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cnt_q));

    // R8: stop freezes the counter and active settings
    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> ($stable(cnt_q) && $stable(mod_act_q)));

    // R8: stop always lands in the halt state
    p_stop_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (st_q == ST_HALT));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CNT_W = 12,
    parameter int NCH   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       stop_i,
    input  logic [CNT_W-1:0]           cnt_i,
    input  logic [NCH-1:0][CNT_W-1:0]  duty_i,
    output logic [NCH-1:0]             pwm_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign pwm_o[c] = !stop_i && (cnt_i != '0) && (cnt_i <= duty_i[c]);
    end

    // R8: stop forces every output low at once
    p_stop_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |-> (pwm_o == '0));

    // R10: counter at zero keeps outputs low
    p_zero_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0) |-> (pwm_o == '0));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwmtb_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int NCH    = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              stop_req,
    output logic [NCH-1:0]    pwm_out
);
    ctrl_t                      ctrl;
    logic [CNT_W-1:0]           mod_sh;
    logic [NCH-1:0][CNT_W-1:0]  duty_sh;
    logic [NCH-1:0][CNT_W-1:0]  duty_act;
    logic [CNT_W-1:0]           cnt;
    logic                       run;
    logic                       tick;

    pwm_regfile #(.CNT_W(CNT_W), .NCH(NCH), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .rd_en  (reg_rd),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .cnt_i  (cnt),
        .rdata  (reg_rdata),
        .ctrl_o (ctrl),
        .mod_o  (mod_sh),
        .duty_o (duty_sh)
    );

    pwm_prescaler #(.SEL_W(PSEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctrl.en),
        .run_i  (run),
        .psel_i (ctrl.psel),
        .tick_o (tick)
    );

    pwm_core #(.CNT_W(CNT_W), .NCH(NCH)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctrl.en),
        .stop_i     (stop_req),
        .tick_i     (tick),
        .mod_i      (mod_sh),
        .duty_i     (duty_sh),
        .run_o      (run),
        .cnt_o      (cnt),
        .duty_act_o (duty_act)
    );

    pwm_compare #(.CNT_W(CNT_W), .NCH(NCH)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .stop_i (stop_req),
        .cnt_i  (cnt),
        .duty_i (duty_act),
        .pwm_o  (pwm_out)
    );
endmodule

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;
    localparam logic [3:0] A_CTRL = 4'd0, A_CHI = 4'd1, A_CLO = 4'd2, A_MHI = 4'd3,
                           A_MLO = 4'd4, A_D0H = 4'd5, A_D0L = 4'd6, A_D1H = 4'd7, A_D1L = 4'd8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, stop_req = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] pwm_out;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    pwm_timebase i_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_req(stop_req), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [1:0]  psel;
        logic [11:0] modv;
        logic [11:0] d0;
        logic [11:0] d1;
        logic [15:0] e_per;
        logic [15:0] e_h0;
        logic [15:0] e_h1;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'd0, 12'd10, 12'd3,  12'd7,  16'd10, 16'd3,  16'd7},
        '{2'd1, 12'd6,  12'd2,  12'd0,  16'd12, 16'd4,  16'd0},
        '{2'd2, 12'd5,  12'd4,  12'd1,  16'd20, 16'd16, 16'd4},
        '{2'd3, 12'd3,  12'd1,  12'd2,  16'd24, 16'd8,  16'd16},
        '{2'd0, 12'd20, 12'd19, 12'd10, 16'd20, 16'd19, 16'd10}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rd_cnt(output int v);
        logic [7:0] hi, lo;
        rd(A_CHI, hi);
        rd(A_CLO, lo);
        v = {hi[3:0], lo};
    endtask

    task automatic wait_rise(input string req);
        logic prev;
        prev = pwm_out[0];
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!prev && pwm_out[0]) return;
            prev = pwm_out[0];
        end
        chk({req, " rise timeout"}, 0, 1);
    endtask

    // called at a rising edge of channel 0; runs to the next one
    task automatic measure(output int per, output int h0, output int h1);
        logic prev;
        per = 0; h0 = 0; h1 = 0;
        do begin
            per++;
            h0 += int'(pwm_out[0]);
            h1 += int'(pwm_out[1]);
            prev = pwm_out[0];
            @(negedge clk);
        end while (!(!prev && pwm_out[0]) && per < 5000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d, hi, lo1, lo2;
        int v1, v2, v3, per, h0, h1, n;
        logic s, ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pwm", int'(pwm_out), 0);
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_CHI, d);  chk("R1 cnt_hi", d, 0);
        rd(A_CLO, d);  chk("R1 cnt_lo", d, 0);
        rd(A_MLO, d);  chk("R1 mod_lo", d, 0);
        rd(A_D1L, d);  chk("R1 duty1_lo", d, 0);

        // R11: register map, padding and read-only counter
        wr(A_MHI, 8'hF5); wr(A_MLO, 8'hA3); wr(A_D1H, 8'hF7); wr(A_CTRL, 8'hFE);
        rd(A_MHI, d); chk("R11 mod_hi", d, 8'h05);
        rd(A_MLO, d); chk("R11 mod_lo", d, 8'hA3);
        rd(A_D1H, d); chk("R11 duty1_hi", d, 8'h07);
        rd(A_CTRL, d); chk("R11 ctrl", d, 8'h06);
        wr(A_CHI, 8'hFF); wr(A_CLO, 8'hFF);
        rd_cnt(v1); chk("R11 counter write ignored", v1, 0);

        // R4/R2: coherent readback while running at full rate
        wr(A_D0H, 8'h0F); wr(A_D0L, 8'hFF); wr(A_D1H, 8'h00);
        wr(A_MHI, 8'h0F); wr(A_MLO, 8'hFF);
        wr(A_CTRL, 8'h01);
        repeat (400) @(negedge clk);
        chk("R5 duty at max keeps high", int'(pwm_out[0]), 1);
        rd(A_CHI, hi);
        chk("R2 hi byte", hi, 8'h01);
        repeat (10) @(negedge clk);
        rd(A_CLO, lo1);
        rd(A_CLO, lo2);
        chk("R4 latched vs live distance", int'(8'(lo2 - lo1)), 12);

        // R7: disable freezes counter and outputs
        wr(A_CTRL, 8'h00);
        repeat (3) @(negedge clk);
        rd_cnt(v1);
        s = pwm_out[0]; ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_out[0] != s) ok = 1'b0;
        end
        chk("R7 output steady", int'(ok), 1);
        rd_cnt(v2);
        chk("R7 counter held", v2, v1);

        // R8/R9: stop forces low and keeps the count
        wr(A_CTRL, 8'h01);
        repeat (5) @(negedge clk);
        chk("R8 high before stop", int'(pwm_out[0]), 1);
        stop_req = 1'b1;
        #1;
        chk("R8 low at once", int'(pwm_out), 0);
        ok = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm_out != 2'b00) ok = 1'b0;
        end
        chk("R8 low during stop", int'(ok), 1);
        rd_cnt(v1);
        repeat (10) @(negedge clk);
        rd_cnt(v2);
        chk("R8 counter held", v2, v1);
        stop_req = 1'b0;
        repeat (20) @(negedge clk);
        rd_cnt(v3);
        chk("R9 resume from held value", int'(v3 > v1 && v3 <= v1 + 40), 1);
        chk("R9 output back", int'(pwm_out[0]), 1);

        // R2/R3/R5: vector table
        for (int k = 0; k < 5; k++) begin
            wr(A_CTRL, {5'b0, VECS[k].psel, 1'b1});
            wr(A_MHI, {4'b0, VECS[k].modv[11:8]}); wr(A_MLO, VECS[k].modv[7:0]);
            wr(A_D0H, {4'b0, VECS[k].d0[11:8]});   wr(A_D0L, VECS[k].d0[7:0]);
            wr(A_D1H, {4'b0, VECS[k].d1[11:8]});   wr(A_D1L, VECS[k].d1[7:0]);
            wait_rise("R2"); wait_rise("R2"); wait_rise("R2");
            measure(per, h0, h1);
            chk($sformatf("R2 R3 period vec%0d", k), per, int'(VECS[k].e_per));
            chk($sformatf("R5 high0 vec%0d", k), h0, int'(VECS[k].e_h0));
            chk($sformatf("R5 high1 vec%0d", k), h1, int'(VECS[k].e_h1));
        end

        // R6: duty written mid-period waits for the wrap
        wr(A_CTRL, 8'h01); wr(A_MHI, 8'h00); wr(A_MLO, 8'd10);
        wr(A_D0H, 8'h00); wr(A_D0L, 8'd3);
        wait_rise("R6"); wait_rise("R6"); wait_rise("R6");
        wr(A_D0L, 8'd7);
        n = 0;
        while (pwm_out[0] && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R6 old duty kept", n, 2);
        wait_rise("R6");
        measure(per, h0, h1);
        chk("R6 new duty at wrap", h0, 7);

        // R10: zero modulus
        wr(A_MHI, 8'h00); wr(A_MLO, 8'h00);
        repeat (40) @(negedge clk);
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_out != 2'b00) ok = 1'b0;
        end
        chk("R10 outputs low", int'(ok), 1);
        rd_cnt(v1);
        chk("R10 counter zero", v1, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule